// File: doc/BRIEF.md
# Serpentine Commutator for a Symmetric Polyphase Filter Bank

This block sits at the front of a polyphase filter bank whose prototype filter is symmetric, so that each pair of mirrored polyphase branches can share one filter. It takes a high-rate stream that arrives as several parallel sample lanes per clock and hands each sample to one of the shared branches. The branch pointer does not wrap. It climbs from the first branch to the last, then runs back down to the first, and then climbs again. Each end branch is therefore fed twice in a row at every reversal.

Each branch has a data register and a one-cycle write strobe. A single phase flag is 0 while the pointer climbs and 1 while it descends. The shared filters use this flag to decide whether a sample belongs to their even or their odd convolution, and it also drives their input and output selectors. One full climb plus one full descent covers twice as many samples as there are branches, and a frame strobe marks the end of each such cycle. Every branch filter also decimates by two, so the overall decimation is twice the number of branches, although only half that many branches are built.

Top module: `serp_commutator`

## Requirements
- R1: A synchronous reset clears every strobe, every branch data word, the phase flag and the frame strobe. The first sample accepted after reset goes to branch index 0.
- R2: On a cycle with `in_valid` high, all LANES samples are taken. Lane 0 (bits SW-1:0) is taken first and lane l sits at bits l*SW +: SW. The pointer moves by one position for each sample taken.
- R3: While climbing, successive samples go to branch indices 0, 1, ..., HALF-1, and `sweep_odd` reads 0 for those batches.
- R4: While descending, successive samples go to branch indices HALF-1, HALF-2, ..., 0, and `sweep_odd` reads 1 for those batches.
- R5: At each reversal the end branch is fed twice in a row: index HALF-1 at the top and index 0 at the bottom. The first batch after a reversal strobes that end branch.
- R6: The results of an accepted batch appear on the clock edge after the one that took it. Exactly LANES bits of `br_wr` are high, each for a single cycle, and each strobed branch shows the sample routed to it.
- R7: A cycle with `in_valid` low strobes no branch, changes no data word or phase flag, and leaves the pointer where it was.
- R8: `frame_done` pulses for one cycle together with the batch that holds the 2*HALF-th sample of a sweep cycle, that is, once every 2*HALF accepted samples.
- R9: A branch that is not strobed keeps its previous data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | All lanes carry a sample this cycle |
| in_lanes | input | LANES*SW | Parallel input samples, lane 0 in the low bits |
| br_wr | output | HALF | Per-branch write strobe |
| br_data | output | HALF*SW | Per-branch sample word, branch b at b*SW +: SW |
| sweep_odd | output | 1 | Phase flag of the latest batch: 0 climbing/even, 1 descending/odd |
| frame_done | output | 1 | One-cycle pulse at the end of each climb-and-descend cycle |

## Verification
Every result (strobes, data words, phase flag and frame strobe) comes from a single register stage. A batch taken on one rising edge therefore appears right after that edge. The bench drives inputs on the falling edge, waits for the next rising edge, and compares one time unit later against a model. The model walks a pointer and a direction flag one sample at a time and reverses with a repeat at each end. The sweep runs many full frames with idle cycles placed so that they fall on turnarounds and mid-sweep, and it includes a reset in the middle of a frame. Each reversal gets an extra look at the end-branch strobe.

// File: rtl/serp_pkg.sv
package serp_pkg;

  // Fold a position in the up-then-down cycle onto a branch index.
  function automatic int unsigned fold_branch(input int unsigned pos,
                                              input int unsigned half);
    if (pos < half) return pos;
    return (2 * half - 1) - pos;
  endfunction

  // Second half of the cycle is the descending (odd) sweep.
  function automatic bit sweep_is_odd(input int unsigned pos,
                                      input int unsigned half);
    return pos >= half;
  endfunction

endpackage

// File: rtl/serp_seq_ptr.sv
module serp_seq_ptr #(
  parameter int HALF  = 16,
  parameter int LANES = 4,
  localparam int CYC  = 2 * HALF,
  localparam int PW   = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] base,
  output logic          wrap_evt
);
  localparam logic [PW-1:0] LAST = PW'(CYC - LANES);

  logic at_last;
  assign at_last  = (base == LAST);
  assign wrap_evt = adv && at_last;

  always_ff @(posedge clk) begin
    if (rst)      base <= '0;
    else if (adv) base <= at_last ? '0 : base + PW'(LANES);
  end

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(base));
  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (base == '0));
endmodule

// File: rtl/serp_lane_router.sv
module serp_lane_router #(
  parameter int HALF  = 16,
  parameter int LANES = 4,
  localparam int PW   = $clog2(2 * HALF),
  localparam int BW   = $clog2(HALF)
) (
  input  logic [PW-1:0]            base,
  output logic [LANES-1:0][BW-1:0] lane_branch,
  output logic                     lane_odd
);
  import serp_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      int unsigned p;
      p = int'(base) + l;
      lane_branch[l] = BW'(fold_branch(p, HALF));
    end
  end

  assign lane_odd = sweep_is_odd(int'(base), HALF);
endmodule

// File: rtl/serp_branch_regs.sv
module serp_branch_regs #(
  parameter int HALF  = 16,
  parameter int LANES = 4,
  parameter int SW    = 16,
  localparam int BW   = $clog2(HALF)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  logic [LANES*SW-1:0]      lanes,
  input  logic [LANES-1:0][BW-1:0] lane_branch,
  input  logic                     lane_odd,
  input  logic                     wrap_evt,
  output logic [HALF-1:0]          br_wr,
  output logic [HALF*SW-1:0]       br_data,
  output logic                     sweep_odd,
  output logic                     frame_done
);
  logic [HALF-1:0]         hit;
  logic [HALF-1:0][SW-1:0] pick;

  always_comb begin
    hit  = '0;
    pick = '0;
    for (int b = 0; b < HALF; b++) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_branch[l] == BW'(b)) begin
          hit[b]  = 1'b1;
          pick[b] = lanes[l*SW +: SW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      br_wr      <= '0;
      br_data    <= '0;
      sweep_odd  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      br_wr      <= valid ? hit : '0;
      frame_done <= wrap_evt;
      if (valid) sweep_odd <= lane_odd;
      for (int b = 0; b < HALF; b++)
        if (valid && hit[b]) br_data[b*SW +: SW] <= pick[b];
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (br_wr == '0) && !frame_done && !sweep_odd);
  assert_wr_count_R6: assert property (@(posedge clk) disable iff (rst)
    (valid) |=> ($countones(br_wr) == LANES));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (br_wr == '0) && $stable(br_data) && $stable(sweep_odd));
  assert_frame_odd_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> sweep_odd && (br_wr[0] == 1'b1));
endmodule

// File: rtl/serp_commutator.sv
module serp_commutator #(
  parameter int HALF  = 16,
  parameter int LANES = 4,
  parameter int SW    = 16,
  localparam int PW   = $clog2(2 * HALF),
  localparam int BW   = $clog2(HALF)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [LANES*SW-1:0]   in_lanes,
  output logic [HALF-1:0]       br_wr,
  output logic [HALF*SW-1:0]    br_data,
  output logic                  sweep_odd,
  output logic                  frame_done
);
  // A batch must never straddle a reversal.
  if ((HALF % LANES) != 0 || SW < 8 || SW > 16) begin : g_bad_cfg
    initial $error("serp_commutator: HALF must be a multiple of LANES, SW in 8..16");
  end

  logic [PW-1:0]            seq_base;
  logic                     seq_wrap;
  logic [LANES-1:0][BW-1:0] lane_branch;
  logic                     lane_odd;

  serp_seq_ptr #(.HALF(HALF), .LANES(LANES)) u_ptr (
    .clk(clk), .rst(rst), .adv(in_valid),
    .base(seq_base), .wrap_evt(seq_wrap)
  );

  serp_lane_router #(.HALF(HALF), .LANES(LANES)) u_route (
    .base(seq_base), .lane_branch(lane_branch), .lane_odd(lane_odd)
  );

  serp_branch_regs #(.HALF(HALF), .LANES(LANES), .SW(SW)) u_regs (
    .clk(clk), .rst(rst), .valid(in_valid), .lanes(in_lanes),
    .lane_branch(lane_branch), .lane_odd(lane_odd), .wrap_evt(seq_wrap),
    .br_wr(br_wr), .br_data(br_data), .sweep_odd(sweep_odd),
    .frame_done(frame_done)
  );

  assert_turn_top_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(sweep_odd) && (br_wr != '0)) |-> br_wr[HALF-1]);
  assert_turn_bottom_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(sweep_odd) && (br_wr != '0)) |-> br_wr[0]);
endmodule

// File: tb/serp_commutator_test.sv
module serp_commutator_test;
  localparam int HALF  = 16;
  localparam int LANES = 4;
  localparam int SW    = 16;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic [LANES*SW-1:0] in_lanes = '0;
  logic [HALF-1:0]     br_wr;
  logic [HALF*SW-1:0]  br_data;
  logic                sweep_odd;
  logic                frame_done;

  always #5 clk = ~clk;

  serp_commutator #(.HALF(HALF), .LANES(LANES), .SW(SW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_lanes(in_lanes),
    .br_wr(br_wr), .br_data(br_data), .sweep_odd(sweep_odd),
    .frame_done(frame_done)
  );

  int checks = 0;
  int fails  = 0;

  // model state: walking pointer with explicit direction
  logic [SW-1:0]   mdata [HALF];
  int              mptr = 0, mdir = 0, mcnt = 0, last_dir = 0, sample_k = 0;
  logic [HALF-1:0] ewr = '0;
  logic            eodd = 1'b0, efd = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit v);
    int first_dir;
    bit turned;
    @(negedge clk);
    rst = r;
    in_valid = v;
    for (int l = 0; l < LANES; l++)
      in_lanes[l*SW +: SW] = SW'((sample_k + l) * 97 + 3 + (sample_k >> 5) * 4099);
    @(posedge clk);
    #1;
    turned = 1'b0;
    first_dir = mdir;
    ewr = '0;
    efd = 1'b0;
    if (r) begin
      mptr = 0; mdir = 0; mcnt = 0; last_dir = 0; eodd = 1'b0;
      for (int b = 0; b < HALF; b++) mdata[b] = '0;
    end else if (v) begin
      turned = (first_dir != last_dir);
      eodd = (first_dir != 0);
      for (int l = 0; l < LANES; l++) begin
        mdata[mptr] = in_lanes[l*SW +: SW];
        ewr[mptr] = 1'b1;
        last_dir = mdir;
        mcnt++;
        if (mcnt == 2 * HALF) begin efd = 1'b1; mcnt = 0; end
        if (mdir == 0) begin
          if (mptr == HALF - 1) mdir = 1; else mptr++;
        end else begin
          if (mptr == 0) mdir = 0; else mptr--;
        end
      end
      sample_k += LANES;
    end
    // compare
    if (r) begin
      chk("R1", "reset strobes", 64'(br_wr), 64'(ewr));
      chk("R1", "reset phase", 64'(sweep_odd), 64'(eodd));
      chk("R1", "reset frame", 64'(frame_done), 64'(efd));
    end else if (v) begin
      chk("R6", "strobes", 64'(br_wr), 64'(ewr));
      chk(eodd ? "R4" : "R3", "phase", 64'(sweep_odd), 64'(eodd));
      chk("R8", "frame_done", 64'(frame_done), 64'(efd));
      if (turned)
        chk("R5", "end branch fed after reversal",
            64'(br_wr[first_dir != 0 ? HALF-1 : 0]), 64'(1));
    end else begin
      chk("R7", "idle strobes", 64'(br_wr), 64'(0));
      chk("R7", "idle phase", 64'(sweep_odd), 64'(eodd));
      chk("R7", "idle frame", 64'(frame_done), 64'(0));
    end
    for (int b = 0; b < HALF; b++)
      chk(r ? "R1" : (!v ? "R7" : (ewr[b] ? "R2" : "R9")), $sformatf("data b%0d", b),
          64'(br_data[b*SW +: SW]), 64'(mdata[b]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    for (int b = 0; b < HALF; b++) mdata[b] = '0;
    step(1, 0);
    step(1, 1);
    // R3,R4 plain frames with no gaps
    for (int i = 0; i < 24; i++) step(0, 1);
    // gaps at several offsets, including at the reversals (R7)
    for (int i = 0; i < 90; i++) step(0, (i % 5) != 3);
    for (int i = 0; i < 40; i++) step(0, (i % 4) == 0 || (i % 9) == 1);
    // reset in the middle of a frame, then resume from branch 0 (R1)
    for (int i = 0; i < 3; i++) step(0, 1);
    step(1, 1);
    step(0, 0);
    for (int i = 0; i < 40; i++) step(0, (i % 7) != 6);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule